// File: doc/BRIEF.md
# Grouped Priority Interrupt Encoder

This block gathers a flat vector of peripheral interrupt request lines and reduces it to one winning request per clock. The lines are organised into groups of equal width. Each group reads a 4-bit priority level from a bank of 16-bit level registers that software writes through a small write port. A level of zero turns the whole group off. Inside a group, a fixed lane order settles which line wins. Across groups, the highest level wins, and when two levels are equal the lower group index wins. A request goes forward only when its level is strictly above the CPU mask level.

For the winner, the block presents three things: its level, its source number, and two event codes. The secondary code is fixed for each source and rises in steps of 0x20. One class of groups can be marked so that all of its lanes report the same secondary code. The primary code is normally a copy of the secondary code. A group marked as level-coded instead takes its primary code from the accepted level, so the code identifies the level and the secondary code still identifies the source. All outputs are registered.

Top module: `grp_irq_encoder`

## Requirements
- R1: After reset every level field is 0, `req_valid_o` is 0, and `level_o`, `src_id_o`, `code_pri_o` and `code_sec_o` are all 0. With every level at 0, no request line can raise `req_valid_o`.
- R2: Level register at write address k holds groups 4k to 4k+3. Group 4k+j sits in bits [15-4j : 12-4j], so the first group of a register is in bits 15..12. A write to an address at or above the register count (2 with the defaults) changes nothing.
- R3: A group takes part only when one of its lines is high and its level is strictly greater than `mask_i`. A level of 0, or a level equal to the mask, forwards nothing.
- R4: Among the groups that take part, the one with the highest level wins, even when the groups sit in different level registers.
- R5: When taking-part groups have equal levels, the group with the lower index wins.
- R6: Inside the winning group, the requesting lane with the lowest index wins. Source number = group × 4 + lane, where line `irq_i[n]` is source n.
- R7: Secondary code = 0x400 + 0x20 × source number. For a shared-code group (group 7 by default), every lane reports the code of that group's lane 0 (0x780).
- R8: For a fixed-code group (groups 0 to 3 by default), primary code = secondary code. For a level-coded group (groups 4 to 7 by default), primary code = 0x200 + 0x20 × (15 − level). This gives 0x200 at level 15 and 0x3C0 at level 1.
- R9: The outputs change on the first rising clock edge after a change in `irq_i`, `mask_i` or a level register, and not before.
- R10: While `req_valid_o` is 0, `level_o`, `src_id_o`, `code_pri_o` and `code_sec_o` keep the values of the last forwarded request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Level register write strobe |
| wr_addr_i | input | 2 | Level register word address |
| wr_data_i | input | 16 | Level register write data |
| mask_i | input | 4 | CPU mask level |
| irq_i | input | 32 | Request lines, group-major, lane-minor |
| req_valid_o | output | 1 | A request above the mask is being forwarded |
| level_o | output | 4 | Level of the forwarded request |
| src_id_o | output | 5 | Source number of the forwarded request |
| code_pri_o | output | 12 | Primary event code |
| code_sec_o | output | 12 | Secondary event code |

## Verification
The hardest case to reach from the ports is a request that is held back while a lower-ranked request is granted. That happens when a higher group is still at level 0 or sits exactly at the mask, and it only shows up when both level registers and several lines across groups are set up together. Each table vector therefore writes both level registers before it drives its line pattern and mask. The vectors pair a blocked group with a smaller competitor: in a different register, in a tie, or in the same shared group. Directed steps then cover the cycle just before and just after an input change, writes to unused addresses, a return to idle while the last codes hold, and a reset in the middle of a run.

// File: rtl/gie_pkg.sv
package gie_pkg;

   localparam int LVL_W   = 4;
   localparam int LVL_MAX = (1 << LVL_W) - 1;
   localparam int FIELDS_PER_REG = 4;
   localparam int REG_W   = LVL_W * FIELDS_PER_REG;

   typedef logic [LVL_W-1:0] lvl_t;

   // Event code that follows the accepted level: highest level gives base.
   function automatic int lvl_vector(input int base, input int step, input lvl_t lvl);
      return base + step * (LVL_MAX - int'(lvl));
   endfunction

   // Index of the source whose fixed code a lane reports.
   function automatic int code_slot(input int grp, input int lane, input int lanes,
                                    input logic shared);
      return shared ? grp * lanes : grp * lanes + lane;
   endfunction

endpackage

// File: rtl/gie_prio_bank.sv
module gie_prio_bank
   import gie_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int ADDR_W     = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_en_i,
   input  logic [ADDR_W-1:0]           wr_addr_i,
   input  logic [REG_W-1:0]            wr_data_i,
   output logic [NUM_GROUPS*LVL_W-1:0] lvl_o
);

   localparam int NUM_REGS = (NUM_GROUPS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

   logic [REG_W-1:0] regs_q [NUM_REGS];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
      end else if (wr_en_i) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            if (wr_addr_i == ADDR_W'(r)) regs_q[r] <= wr_data_i;
         end
      end
   end

   // Group 4k+j reads the field that starts at the top of word k.
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_field
      localparam int WORD = g / FIELDS_PER_REG;
      localparam int TOP  = REG_W - 1 - LVL_W * (g % FIELDS_PER_REG);
      assign lvl_o[g*LVL_W +: LVL_W] = regs_q[WORD][TOP -: LVL_W];
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
      // R2
      reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_en_i && wr_addr_i == ADDR_W'(r)) |=> (regs_q[r] == $past(wr_data_i)));
      // R2
      reg_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_en_i && int'(wr_addr_i) >= NUM_REGS) |=> $stable(regs_q[r]));
   end

endmodule

// File: rtl/gie_group_pick.sv
module gie_group_pick
   import gie_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 2
) (
   input  logic [LANES-1:0]  req_i,
   input  lvl_t              lvl_i,
   input  lvl_t              mask_i,
   output logic              valid_o,
   output logic [LANE_W-1:0] lane_o
);

   logic [LANE_W-1:0] lane_sel;

   // Scan from the top lane down so the lowest requesting lane is kept last.
   always_comb begin
      lane_sel = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
         if (req_i[l]) lane_sel = LANE_W'(l);
      end
   end

   assign lane_o  = lane_sel;
   assign valid_o = (|req_i) && (lvl_i > mask_i);

   always_comb begin
      if (valid_o) begin
         for (int l = 0; l < LANES; l++) begin
            // R6
            if (LANE_W'(l) < lane_o) lane_low_chk: assert (!req_i[l]);
            // R6
            if (LANE_W'(l) == lane_o) lane_hit_chk: assert (req_i[l]);
         end
      end
   end

endmodule

// File: rtl/gie_arbiter.sv
module gie_arbiter
   import gie_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int GRP_W      = 3,
   parameter int LANE_W     = 2
) (
   input  logic [NUM_GROUPS-1:0]        grp_valid_i,
   input  logic [NUM_GROUPS*LVL_W-1:0]  grp_lvl_i,
   input  logic [NUM_GROUPS*LANE_W-1:0] grp_lane_i,
   output logic                         win_valid_o,
   output logic [GRP_W-1:0]             win_grp_o,
   output lvl_t                         win_lvl_o,
   output logic [LANE_W-1:0]            win_lane_o
);

   logic              best_valid;
   logic [GRP_W-1:0]  best_grp;
   lvl_t              best_lvl;
   logic [LANE_W-1:0] best_lane;

   // Strictly-greater compare keeps the earlier (lower index) group on a tie.
   always_comb begin
      best_valid = 1'b0;
      best_grp   = '0;
      best_lvl   = '0;
      best_lane  = '0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (grp_valid_i[g] && (!best_valid || grp_lvl_i[g*LVL_W +: LVL_W] > best_lvl)) begin
            best_valid = 1'b1;
            best_grp   = GRP_W'(g);
            best_lvl   = grp_lvl_i[g*LVL_W +: LVL_W];
            best_lane  = grp_lane_i[g*LANE_W +: LANE_W];
         end
      end
   end

   assign win_valid_o = best_valid;
   assign win_grp_o   = best_grp;
   assign win_lvl_o   = best_lvl;
   assign win_lane_o  = best_lane;

   always_comb begin
      if (win_valid_o) begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_valid_i[g]) begin
               // R4
               win_top_chk: assert (grp_lvl_i[g*LVL_W +: LVL_W] <= win_lvl_o);
               // R5
               if (GRP_W'(g) < win_grp_o)
                  win_tie_chk: assert (grp_lvl_i[g*LVL_W +: LVL_W] < win_lvl_o);
            end
         end
      end
   end

endmodule

// File: rtl/grp_irq_encoder.sv
module grp_irq_encoder
   import gie_pkg::*;
#(
   parameter int                  NUM_GROUPS    = 8,
   parameter int                  LANES         = 4,
   parameter int                  ADDR_W        = 2,
   parameter int                  CODE_W        = 12,
   parameter int                  SEC_BASE      = 'h400,
   parameter int                  LVL_BASE      = 'h200,
   parameter int                  CODE_STEP     = 'h20,
   parameter logic [NUM_GROUPS-1:0] LVL_CODE_GRPS = 8'b1111_0000,
   parameter logic [NUM_GROUPS-1:0] SHARED_GRPS   = 8'b1000_0000,
   localparam int                 NUM_SRC       = NUM_GROUPS * LANES,
   localparam int                 SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [15:0]       wr_data_i,
   input  logic [3:0]        mask_i,
   input  logic [NUM_SRC-1:0] irq_i,
   output logic              req_valid_o,
   output logic [3:0]        level_o,
   output logic [SRC_W-1:0]  src_id_o,
   output logic [CODE_W-1:0] code_pri_o,
   output logic [CODE_W-1:0] code_sec_o
);

   localparam int NUM_REGS = (NUM_GROUPS + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
   localparam int GRP_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int CODE_TOP = SEC_BASE + CODE_STEP * (NUM_SRC - 1);

   // Elaboration-time parameter checks.
   if (NUM_GROUPS < 1 || LANES < 1) begin : g_bad_shape
      $error("grp_irq_encoder: NUM_GROUPS and LANES must be at least 1");
   end
   if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
      $error("grp_irq_encoder: ADDR_W too narrow for the level registers");
   end
   if (CODE_TOP >= (1 << CODE_W) || LVL_BASE + CODE_STEP * LVL_MAX >= (1 << CODE_W)) begin : g_bad_code
      $error("grp_irq_encoder: CODE_W too narrow for the event codes");
   end

   logic [NUM_GROUPS*LVL_W-1:0]  grp_lvl;
   logic [NUM_GROUPS-1:0]        grp_valid;
   logic [NUM_GROUPS*LANE_W-1:0] grp_lane;

   gie_prio_bank #(
      .NUM_GROUPS (NUM_GROUPS),
      .ADDR_W     (ADDR_W)
   ) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .lvl_o     (grp_lvl)
   );

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      gie_group_pick #(
         .LANES  (LANES),
         .LANE_W (LANE_W)
      ) pick_i (
         .req_i   (irq_i[g*LANES +: LANES]),
         .lvl_i   (grp_lvl[g*LVL_W +: LVL_W]),
         .mask_i  (mask_i),
         .valid_o (grp_valid[g]),
         .lane_o  (grp_lane[g*LANE_W +: LANE_W])
      );
   end

   logic              win_valid;
   logic [GRP_W-1:0]  win_grp;
   lvl_t              win_lvl;
   logic [LANE_W-1:0] win_lane;

   gie_arbiter #(
      .NUM_GROUPS (NUM_GROUPS),
      .GRP_W      (GRP_W),
      .LANE_W     (LANE_W)
   ) arb_i (
      .grp_valid_i (grp_valid),
      .grp_lvl_i   (grp_lvl),
      .grp_lane_i  (grp_lane),
      .win_valid_o (win_valid),
      .win_grp_o   (win_grp),
      .win_lvl_o   (win_lvl),
      .win_lane_o  (win_lane)
   );

   // Code generation for the winner.
   int                win_src_n;
   int                win_slot_n;
   logic [CODE_W-1:0] sec_code;
   logic [CODE_W-1:0] pri_code;

   always_comb begin
      win_src_n  = int'(win_grp) * LANES + int'(win_lane);
      win_slot_n = code_slot(int'(win_grp), int'(win_lane), LANES, SHARED_GRPS[win_grp]);
      sec_code   = CODE_W'(SEC_BASE + CODE_STEP * win_slot_n);
      if (LVL_CODE_GRPS[win_grp]) pri_code = CODE_W'(lvl_vector(LVL_BASE, CODE_STEP, win_lvl));
      else                        pri_code = sec_code;
   end

   // Output stage: payload loads only with a forwarded request.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         req_valid_o <= 1'b0;
         level_o     <= '0;
         src_id_o    <= '0;
         code_pri_o  <= '0;
         code_sec_o  <= '0;
      end else begin
         req_valid_o <= win_valid;
         if (win_valid) begin
            level_o    <= win_lvl;
            src_id_o   <= SRC_W'(win_src_n);
            code_pri_o <= pri_code;
            code_sec_o <= sec_code;
         end
      end
   end

   // R3
   lvl_above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> (level_o > $past(mask_i)));

   // R3
   lvl_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_o |-> (level_o != '0));

   // R10
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_o |-> ($stable(code_pri_o) && $stable(code_sec_o) &&
                        $stable(src_id_o) && $stable(level_o)));

   // R9
   valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(irq_i) == '0) |-> !req_valid_o);

endmodule

// File: tb/grp_irq_encoder_tb_top.sv
module grp_irq_encoder_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  mask = '0;
   logic [31:0] irq = '0;
   logic        valid;
   logic [3:0]  lvl;
   logic [4:0]  src;
   logic [11:0] pri;
   logic [11:0] sec;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   grp_irq_encoder dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .mask_i      (mask),
      .irq_i       (irq),
      .req_valid_o (valid),
      .level_o     (lvl),
      .src_id_o    (src),
      .code_pri_o  (pri),
      .code_sec_o  (sec)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [15:0] reg0;
      logic [15:0] reg1;
      logic [3:0]  mask;
      logic [31:0] irq;
      logic        v;
      logic [3:0]  lvl;
      logic [4:0]  src;
      logic [11:0] pri;
      logic [11:0] sec;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      // R3: every level 0, all lines high
      '{4'd3, 16'h0000, 16'h0000, 4'd0, 32'hFFFF_FFFF, 1'b0, 4'd0,  5'd0,  12'h000, 12'h000},
      // R4 R7: g2 (lvl 3) beats g0 (lvl 1)
      '{4'd4, 16'h1234, 16'h0000, 4'd0, 32'h0000_0101, 1'b1, 4'd3,  5'd8,  12'h500, 12'h500},
      // R6: g3 lanes 1 and 3, lane 1 wins
      '{4'd6, 16'h1234, 16'h0000, 4'd0, 32'h0000_A000, 1'b1, 4'd4,  5'd13, 12'h5A0, 12'h5A0},
      // R5: g0 and g1 both level 5, g0 wins
      '{4'd5, 16'h5500, 16'h0000, 4'd0, 32'h0000_0014, 1'b1, 4'd5,  5'd2,  12'h440, 12'h440},
      // R8: level-coded g5 at level 10
      '{4'd8, 16'h0000, 16'h0A00, 4'd0, 32'h0080_0000, 1'b1, 4'd10, 5'd23, 12'h2A0, 12'h6E0},
      // R7: shared g7 lane 2, level 15
      '{4'd7, 16'h0000, 16'h000F, 4'd0, 32'h4000_0000, 1'b1, 4'd15, 5'd30, 12'h200, 12'h780},
      // R3: level equal to mask is blocked
      '{4'd3, 16'h3000, 16'h0000, 4'd3, 32'h0000_0001, 1'b0, 4'd0,  5'd0,  12'h000, 12'h000},
      // R3: level one above mask passes
      '{4'd3, 16'h3000, 16'h0000, 4'd2, 32'h0000_0001, 1'b1, 4'd3,  5'd0,  12'h400, 12'h400},
      // R3: g0 at level 0 loses to g1 at level 1
      '{4'd3, 16'h0100, 16'h0000, 4'd0, 32'h0000_0011, 1'b1, 4'd1,  5'd4,  12'h480, 12'h480},
      // R4: g6 in word 1 (lvl 8) beats g0 in word 0 (lvl 7)
      '{4'd4, 16'h7000, 16'h0080, 4'd0, 32'h0100_0001, 1'b1, 4'd8,  5'd24, 12'h2E0, 12'h700},
      // R8: level 1 gives the last level code
      '{4'd8, 16'h0000, 16'h1000, 4'd0, 32'h0001_0000, 1'b1, 4'd1,  5'd16, 12'h3C0, 12'h600},
      // R6: shared g7 lanes 1 and 3, lane 1 wins
      '{4'd6, 16'h0000, 16'h0002, 4'd0, 32'hA000_0000, 1'b1, 4'd2,  5'd29, 12'h3A0, 12'h780}
   };

   task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic apply(input logic [3:0] m, input logic [31:0] r);
      @(negedge clk);
      mask = m;
      irq  = r;
      @(negedge clk);
   endtask

   task automatic expect_out(input string tag, input logic ev, input logic [3:0] el,
                             input logic [4:0] es, input logic [11:0] ep,
                             input logic [11:0] esec, input logic full);
      logic bad;
      n_checks++;
      bad = (valid !== ev);
      if (full) bad = bad || (lvl !== el) || (src !== es) || (pri !== ep) || (sec !== esec);
      if (bad) begin
         n_fails++;
         $display("FAIL %s: got v=%0d lvl=%0d src=%0d pri=%h sec=%h, expected v=%0d lvl=%0d src=%0d pri=%h sec=%h",
                  tag, valid, lvl, src, pri, sec, ev, el, es, ep, esec);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fails++;
      $display("FAIL watchdog: got timeout, expected end of run");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs cleared during and after reset
      expect_out("R1 in reset", 1'b0, 4'd0, 5'd0, 12'h000, 12'h000, 1'b1);
      rst_n = 1'b1;
      apply(4'd0, 32'hFFFF_FFFF);
      // R1: all levels reset to 0 so nothing forwards
      expect_out("R1 after reset", 1'b0, 4'd0, 5'd0, 12'h000, 12'h000, 1'b1);

      for (int i = 0; i < NVEC; i++) begin
         write_reg(2'd0, VECS[i].reg0);
         write_reg(2'd1, VECS[i].reg1);
         apply(VECS[i].mask, VECS[i].irq);
         expect_out($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].v, VECS[i].lvl,
                    VECS[i].src, VECS[i].pri, VECS[i].sec, VECS[i].v);
      end

      // R10: drop all lines, payload of last winner stays
      apply(4'd0, 32'h0);
      expect_out("R10 hold", 1'b0, 4'd2, 5'd29, 12'h3A0, 12'h780, 1'b1);

      // R2: writes to addresses 2 and 3 must not reach any level field
      write_reg(2'd0, 16'h0000);
      write_reg(2'd1, 16'h0000);
      write_reg(2'd2, 16'hFFFF);
      write_reg(2'd3, 16'hFFFF);
      apply(4'd0, 32'hFFFF_FFFF);
      expect_out("R2 unused address", 1'b0, 4'd2, 5'd29, 12'h3A0, 12'h780, 1'b1);

      // R2: field position, g1 is bits 11..8 of word 0
      write_reg(2'd0, 16'h0900);
      apply(4'd0, 32'h0000_00F1);
      expect_out("R2 field g1", 1'b1, 4'd9, 5'd4, 12'h480, 12'h480, 1'b1);

      // R9: change is invisible before the edge, visible after it
      apply(4'd0, 32'h0);
      write_reg(2'd0, 16'hF000);
      @(negedge clk);
      irq = 32'h0000_0002;
      #1;
      expect_out("R9 before edge", 1'b0, 4'd9, 5'd4, 12'h480, 12'h480, 1'b1);
      @(negedge clk);
      expect_out("R9 after edge", 1'b1, 4'd15, 5'd1, 12'h420, 12'h420, 1'b1);

      // R1: reset mid-run clears outputs and level fields
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      expect_out("R1 mid-run reset", 1'b0, 4'd0, 5'd0, 12'h000, 12'h000, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      apply(4'd0, 32'hFFFF_FFFF);
      expect_out("R1 levels cleared", 1'b0, 4'd0, 5'd0, 12'h000, 12'h000, 1'b1);

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule